// File: doc/BRIEF.md
# Masked Vector Lane Extract Unit

The unit takes a 256-bit or 512-bit source vector and pulls out one 128-bit or one 256-bit slice, chosen by the low bits of an immediate byte. The slice is placed at the bottom of a 512-bit destination image. A per-element writemask decides which elements take the new data. The elements are 32 bits wide for single-precision forms and 64 bits wide for double-precision forms, whatever the slice size.

When the destination is a register, an element the mask leaves out is either kept from the old destination (merge) or cleared (zeroing), and everything above the slice is cleared. When the destination is memory, only merging applies. The image above the slice keeps the old contents, and a per-byte write-enable vector tells the memory path which bytes to store. An unmasked legacy form always takes a 128-bit slice from a 256-bit source. Encodings that are not allowed raise an error flag. A request is accepted on any cycle and its result appears one cycle later.

Top module: `lx_extract_unit`

## Requirements
- R1: For a 128-bit slice from a 256-bit source (`slice_wide`=0, `src_wide`=0), `imm[0]`=0 selects source bits 127:0 and `imm[0]`=1 selects bits 255:128.
- R2: For a 128-bit slice from a 512-bit source (`slice_wide`=0, `src_wide`=1), `imm[1:0]`=n selects source bits 128n+127:128n. Code 00 gives 127:0 and code 11 gives 511:384.
- R3: For a 256-bit slice (`slice_wide`=1, `src_wide`=1), `imm[0]`=0 selects bits 255:0 and `imm[0]`=1 selects bits 511:256.
- R4: Element j of the slice is controlled by `mask[j]`, counting from the lowest element. Elements are 32 bits when `elem_dbl`=0 (4 or 8 elements) and 64 bits when `elem_dbl`=1 (2 or 4 elements). Mask bits beyond the element count have no effect.
- R5: Register destination (`to_mem`=0) with `zeroing`=0: an element whose enable is off keeps its old destination value.
- R6: Register destination with `zeroing`=1: an element whose enable is off reads zero.
- R7: Register destination: all `dst_out` bits at or above the slice size (128 or 256) are zero.
- R8: Memory destination (`to_mem`=1): an element whose enable is off keeps its old value even when `zeroing`=1, and bits above the slice keep the old value. `byte_en[b]` is 1 exactly when byte b lies in an enabled element of the slice. For a register destination, `byte_en` is all zero.
- R9: With `use_mask`=0, every element of the slice is enabled, whatever `mask` holds.
- R10: Legacy form (`legacy`=1): a 128-bit slice is taken from the low 256 bits by `imm[0]` with no writemask, ignoring `slice_wide`, `src_wide` and `use_mask`. It is legal only with `vl_bit`=1.
- R11: `illegal` is raised in three cases: `spec` differs from 4'b1111, the legacy form is used with `vl_bit`=0, or a 256-bit slice is requested from a 256-bit source. When `illegal` is raised, `dst_out` equals `old_dst` and `byte_en` is zero.
- R12: `imm[7:2]` has no effect on the result.
- R13: Results appear one cycle after `req_valid`, with `rsp_valid` high for that cycle. Reset clears `rsp_valid`, `dst_out`, `byte_en` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Source vector |
| old_dst | input | 512 | Previous destination contents |
| imm | input | 8 | Immediate byte carrying the slice index |
| slice_wide | input | 1 | 0: 128-bit slice, 1: 256-bit slice |
| src_wide | input | 1 | 0: 256-bit source, 1: 512-bit source |
| elem_dbl | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| mask | input | 8 | Per-element writemask |
| use_mask | input | 1 | Writemask in use |
| zeroing | input | 1 | Zeroing rather than merging (register destination only) |
| to_mem | input | 1 | Destination is memory |
| legacy | input | 1 | Unmasked legacy 128-bit form |
| vl_bit | input | 1 | Vector-length bit of the legacy encoding |
| spec | input | 4 | Reserved specifier field |
| rsp_valid | output | 1 | Result valid |
| dst_out | output | 512 | Updated destination image |
| byte_en | output | 64 | Per-byte store enables for a memory destination |
| illegal | output | 1 | Undefined-encoding error |

## Verification
The bench walks every immediate code for each slice and source size, with junk in the upper immediate bits. A design that decoded the wrong bits, or read `imm[1]` for a 256-bit source, would return the wrong quarter. It mixes 64-bit elements with 128-bit slices, where only two mask bits count. A design that kept 32-bit granularity there would split elements or follow stray mask bits.

On memory destinations it sets `zeroing` and expects old data and an exact byte-enable pattern. A design that applied register rules would clear data or the upper half. Illegal encodings are checked to leave the destination untouched. A design that lets the result through anyway would corrupt `dst_out` or assert `byte_en`.

// File: rtl/lx_pkg.sv
package lx_pkg;

    localparam int SRC_W   = 512;
    localparam int LANE_W  = 32;
    localparam int LANES   = SRC_W / LANE_W;
    localparam int BYTES   = SRC_W / 8;
    localparam int LANE_B  = LANE_W / 8;
    localparam int MASK_W  = 8;
    localparam int SLICE_W = 256;
    localparam int QUART_W = 128;

    typedef enum logic {
        SLICE_NARROW = 1'b0,
        SLICE_WIDE   = 1'b1
    } lx_slice_e;

    typedef struct packed {
        logic [SRC_W-1:0]  dst;
        logic [BYTES-1:0]  be;
        logic              err;
    } lx_rsp_t;

    function automatic logic lx_bad_encoding(
        input logic [3:0] spec,
        input logic       legacy,
        input logic       vl_bit,
        input logic       slice_wide,
        input logic       src_wide
    );
        return (spec != 4'b1111) || (legacy && !vl_bit) ||
               (!legacy && slice_wide && !src_wide);
    endfunction

endpackage

// File: rtl/lx_slice_sel.sv
module lx_slice_sel
    import lx_pkg::*;
#(
    parameter int SW = SRC_W,
    parameter int QW = QUART_W,
    parameter int OW = SLICE_W
) (
    input  logic [SW-1:0] src,
    input  lx_slice_e     size,
    input  logic          from_wide,
    input  logic [1:0]    idx,
    output logic [OW-1:0] slice
);
    localparam int NQ = SW / QW;

    logic [1:0]    quarter;
    logic [SW-1:0] shifted;

    always_comb begin
        if (size == SLICE_WIDE) quarter = {idx[0], 1'b0};
        else if (from_wide)     quarter = idx;
        else                    quarter = {1'b0, idx[0]};
    end

    logic [QW-1:0] quarters [NQ];
    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign quarters[q] = src[q*QW +: QW];
    end

    always_comb begin
        shifted = '0;
        for (int q = 0; q < NQ; q++) begin
            if (q + int'(quarter) < NQ)
                shifted[q*QW +: QW] = quarters[q + int'(quarter)];
        end
        slice = shifted[OW-1:0];
        if (size == SLICE_NARROW) slice[OW-1:QW] = '0;
    end

endmodule

// File: rtl/lx_elem_mask.sv
module lx_elem_mask
    import lx_pkg::*;
#(
    parameter int NL = LANES,
    parameter int MW = MASK_W
) (
    input  logic [MW-1:0] mask,
    input  logic          masked,
    input  logic          dbl,
    input  lx_slice_e     size,
    output logic [NL-1:0] lane_en
);
    logic [4:0] lim;
    assign lim = (size == SLICE_WIDE) ? 5'd8 : 5'd4;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic in_slice;
        logic sel_bit;
        assign in_slice = (l < int'(lim));
        if (l < MW) begin : g_m
            assign sel_bit = dbl ? mask[l/2] : mask[l];
        end else begin : g_n
            assign sel_bit = 1'b0;
        end
        assign lane_en[l] = in_slice && (!masked || sel_bit);
    end

endmodule

// File: rtl/lx_merge.sv
module lx_merge
    import lx_pkg::*;
#(
    parameter int SW = SRC_W,
    parameter int OW = SLICE_W,
    parameter int LW = LANE_W
) (
    input  logic [OW-1:0]      slice,
    input  logic [SW-1:0]      old,
    input  logic [SW/LW-1:0]   lane_en,
    input  lx_slice_e          size,
    input  logic               zeroing,
    input  logic               to_mem,
    output logic [SW-1:0]      dst,
    output logic [SW/8-1:0]    be
);
    localparam int NL = SW / LW;
    localparam int SL = OW / LW;
    localparam int LB = LW / 8;

    logic [4:0] lim;
    assign lim = (size == SLICE_WIDE) ? 5'd8 : 5'd4;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0] keep;
        assign keep = (to_mem || !zeroing) ? old[l*LW +: LW] : '0;
        if (l < SL) begin : g_in
            always_comb begin
                if (l < int'(lim))
                    dst[l*LW +: LW] = lane_en[l] ? slice[l*LW +: LW] : keep;
                else
                    dst[l*LW +: LW] = to_mem ? old[l*LW +: LW] : '0;
            end
        end else begin : g_out
            assign dst[l*LW +: LW] = to_mem ? old[l*LW +: LW] : '0;
        end
        assign be[l*LB +: LB] = {LB{to_mem && lane_en[l]}};
    end

endmodule

// File: rtl/lx_extract_unit.sv
module lx_extract_unit
    import lx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [SRC_W-1:0]    src_vec,
    input  logic [SRC_W-1:0]    old_dst,
    input  logic [7:0]          imm,
    input  logic                slice_wide,
    input  logic                src_wide,
    input  logic                elem_dbl,
    input  logic [MASK_W-1:0]   mask,
    input  logic                use_mask,
    input  logic                zeroing,
    input  logic                to_mem,
    input  logic                legacy,
    input  logic                vl_bit,
    input  logic [3:0]          spec,
    output logic                rsp_valid,
    output logic [SRC_W-1:0]    dst_out,
    output logic [BYTES-1:0]    byte_en,
    output logic                illegal
);
    lx_slice_e         size;
    logic              from_wide;
    logic              masked;
    logic              bad;
    logic [SLICE_W-1:0] slice;
    logic [LANES-1:0]  lane_en;
    logic [SRC_W-1:0]  merged;
    logic [BYTES-1:0]  merged_be;
    lx_rsp_t           nxt, cur;

    assign size      = (slice_wide && !legacy) ? SLICE_WIDE : SLICE_NARROW;
    assign from_wide = src_wide && !legacy;
    assign masked    = use_mask && !legacy;
    assign bad       = lx_bad_encoding(spec, legacy, vl_bit, slice_wide, src_wide);

    lx_slice_sel u_sel (
        .src(src_vec), .size(size), .from_wide(from_wide),
        .idx(imm[1:0]), .slice(slice)
    );

    lx_elem_mask u_mask (
        .mask(mask), .masked(masked), .dbl(elem_dbl),
        .size(size), .lane_en(lane_en)
    );

    lx_merge u_merge (
        .slice(slice), .old(old_dst), .lane_en(lane_en), .size(size),
        .zeroing(zeroing), .to_mem(to_mem), .dst(merged), .be(merged_be)
    );

    always_comb begin
        nxt.err = bad;
        nxt.dst = bad ? old_dst : merged;
        nxt.be  = bad ? '0 : merged_be;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur       <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign dst_out = cur.dst;
    assign byte_en = cur.be;
    assign illegal = cur.err;

    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_bad_spec_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && spec != 4'b1111) |=> (illegal && byte_en == '0));

    assert_legacy_vl_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && legacy && !vl_bit) |=> illegal);

    assert_reg_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !to_mem && spec == 4'b1111 && !legacy && !slice_wide)
        |=> dst_out[SRC_W-1:QUART_W] == '0);

    assert_mem_upper_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && to_mem)
        |=> dst_out[SRC_W-1:SLICE_W] == $past(old_dst[SRC_W-1:SLICE_W]));

    assert_reg_no_be_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !to_mem) |=> byte_en == '0);

endmodule

// File: tb/lx_extract_unit_tb.sv
module lx_extract_unit_tb;
    import lx_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic [SRC_W-1:0] src_vec, old_dst;
    logic [7:0] imm;
    logic slice_wide, src_wide, elem_dbl, use_mask, zeroing, to_mem, legacy, vl_bit;
    logic [MASK_W-1:0] mask;
    logic [3:0] spec;
    logic rsp_valid, illegal;
    logic [SRC_W-1:0] dst_out;
    logic [BYTES-1:0] byte_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lx_extract_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .src_vec(src_vec),
        .old_dst(old_dst), .imm(imm), .slice_wide(slice_wide), .src_wide(src_wide),
        .elem_dbl(elem_dbl), .mask(mask), .use_mask(use_mask), .zeroing(zeroing),
        .to_mem(to_mem), .legacy(legacy), .vl_bit(vl_bit), .spec(spec),
        .rsp_valid(rsp_valid), .dst_out(dst_out), .byte_en(byte_en), .illegal(illegal)
    );

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [SRC_W-1:0] act, input logic [SRC_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model(output logic [SRC_W-1:0] d, output logic [BYTES-1:0] be,
                         output logic ill);
        int base, nl, e;
        logic wide, um, en;
        ill = (spec != 4'b1111) || (legacy && !vl_bit) || (!legacy && slice_wide && !src_wide);
        d = old_dst; be = '0;
        if (ill) return;
        wide = slice_wide && !legacy;
        um   = use_mask && !legacy;
        nl   = wide ? 8 : 4;
        if (wide)                  base = imm[0] * 8;
        else if (src_wide && !legacy) base = int'(imm[1:0]) * 4;
        else                       base = imm[0] * 4;
        for (int l = 0; l < 16; l++) begin
            if (l < nl) begin
                e  = elem_dbl ? l / 2 : l;
                en = !um || mask[e];
                if (en) d[l*32 +: 32] = src_vec[(base+l)*32 +: 32];
                else    d[l*32 +: 32] = (to_mem || !zeroing) ? old_dst[l*32 +: 32] : 32'h0;
                if (to_mem && en) be[l*4 +: 4] = 4'hF;
            end else begin
                d[l*32 +: 32] = to_mem ? old_dst[l*32 +: 32] : 32'h0;
            end
        end
    endtask

    task automatic setup(input logic [7:0] i, input logic sw, input logic srw,
                         input logic dbl, input logic [7:0] m, input logic um,
                         input logic z, input logic mem);
        imm = i; slice_wide = sw; src_wide = srw; elem_dbl = dbl; mask = m;
        use_mask = um; zeroing = z; to_mem = mem; legacy = 1'b0; vl_bit = 1'b1;
        spec = 4'b1111;
    endtask

    task automatic run(input string tag);
        logic [SRC_W-1:0] ed;
        logic [BYTES-1:0] eb;
        logic ei;
        model(ed, eb, ei);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, rsp_valid === 1'b1, "rsp_valid", {511'b0, rsp_valid}, 512'd1);
        check(tag, dst_out === ed, "dst_out", dst_out, ed);
        check(tag, byte_en === eb, "byte_en", {448'b0, byte_en}, {448'b0, eb});
        check(tag, illegal === ei, "illegal", {511'b0, illegal}, {511'b0, ei});
    endtask

    task automatic t_reset;
        check("R13", rsp_valid === 1'b0 && dst_out === '0 && byte_en === '0 && illegal === 1'b0,
              "reset state", dst_out, '0);
    endtask

    task automatic t_sel_128_of_256;
        setup(8'hFC, 0, 0, 0, 8'h00, 0, 0, 0); run("R1");
        setup(8'hFD, 0, 0, 0, 8'h00, 0, 0, 0); run("R1");
        setup(8'h03, 0, 0, 0, 8'h00, 0, 0, 0); run("R12");
    endtask

    task automatic t_sel_128_of_512;
        for (int q = 0; q < 4; q++) begin
            setup({6'b101101, q[1:0]}, 0, 1, 0, 8'h0F, 1, 0, 0); run("R2");
        end
    endtask

    task automatic t_sel_256;
        setup(8'hAA, 1, 1, 0, 8'hFF, 1, 0, 0); run("R3");
        setup(8'h55, 1, 1, 0, 8'hFF, 1, 0, 0); run("R3");
    endtask

    task automatic t_merge_zero;
        setup(8'h01, 1, 1, 0, 8'hA5, 1, 0, 0); run("R5");
        setup(8'h02, 0, 1, 0, 8'hF6, 1, 1, 0); run("R6");
        setup(8'h00, 0, 1, 0, 8'h03, 1, 1, 0); run("R7");
    endtask

    task automatic t_dbl;
        setup(8'h03, 0, 1, 1, 8'hFE, 1, 1, 0); run("R4");
        setup(8'h01, 1, 1, 1, 8'hF9, 1, 0, 0); run("R4");
    endtask

    task automatic t_mem;
        setup(8'h01, 0, 1, 0, 8'h05, 1, 1, 1); run("R8");
        setup(8'h00, 1, 1, 1, 8'h0A, 1, 1, 1); run("R8");
    endtask

    task automatic t_nomask;
        setup(8'h02, 0, 1, 0, 8'h00, 0, 1, 0); run("R9");
        setup(8'h01, 1, 1, 1, 8'h00, 0, 1, 1); run("R9");
    endtask

    task automatic t_legacy;
        setup(8'hF1, 1, 1, 0, 8'h00, 1, 1, 0); legacy = 1'b1; run("R10");
        setup(8'h00, 0, 0, 0, 8'hFF, 0, 0, 0); legacy = 1'b1; vl_bit = 1'b0; run("R10");
    endtask

    task automatic t_illegal;
        setup(8'h01, 0, 1, 0, 8'hFF, 0, 0, 1); spec = 4'b0111; run("R11");
        setup(8'h01, 1, 0, 0, 8'hFF, 0, 0, 0); run("R11");
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R13", rsp_valid === 1'b0, "rsp_valid idle", {511'b0, rsp_valid}, '0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int l = 0; l < 16; l++) begin
            src_vec[l*32 +: 32] = 32'h5A00_0000 | l;
            old_dst[l*32 +: 32] = 32'hC300_0000 | l;
        end
        req_valid = 1'b0;
        setup(8'h00, 0, 0, 0, 8'h00, 0, 0, 0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_sel_128_of_256();
        t_sel_128_of_512();
        t_sel_256();
        t_merge_zero();
        t_dbl();
        t_mem();
        t_nomask();
        t_legacy();
        t_illegal();
        t_idle();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule